// File: doc/BRIEF.md
# FIFO Threshold Offset Loader

This unit holds the two threshold offsets that a FIFO's flag logic compares against its fill level: the almost-empty offset and the almost-full offset. Neither has a port of its own. Both are loaded through the FIFO's data input while a load-select input is held high together with the write enable. Both are read back on the data output while load-select is high together with the read enable.

A one-bit selector decides which offset the next access reaches. Every load access, whether a write or a read, moves the selector one step. It starts at the almost-empty offset, steps to the almost-full offset, and then returns to the almost-empty offset. Software can therefore program or dump both values with two back-to-back accesses.

While load-select is high, no access reaches the FIFO storage. While it is low, the unit passes the FIFO enables through and leaves its own state alone. Writes and reads share one clock in this unit. The two current offsets are driven out continuously to the flag logic.

Top module: `flag_ofs_loader`

## Requirements
- R1: When reset is released, both offsets hold the value 7, the selector points at the almost-empty offset, `data_o` is 0 and `rd_valid_o` is 0.
- R2: A clock edge with `load_sel_i`=1 and `wr_en_i`=1 stores the low OFS_W bits of `data_i` into the offset that the selector points at. The other offset keeps its value.
- R3: Writes and reads use one shared order: the almost-empty offset (selector 0), then the almost-full offset (selector 1), then back to the almost-empty offset. Each load write or load read moves the selector one step.
- R4: A clock edge with `load_sel_i`=1 and `rd_en_i`=1 places the selected offset on `data_o` and sets `rd_valid_o` for one cycle. Both outputs are visible after that edge. At any other time `data_o` keeps its last value.
- R5: When `load_sel_i`, `wr_en_i` and `rd_en_i` are all 1 in the same cycle, the read returns the value the selected offset held before that edge. The write stores the new value into that same offset. The selector moves exactly one step.
- R6: `fifo_wr_o` equals `wr_en_i` and `fifo_rd_o` equals `rd_en_i` while `load_sel_i`=0; in that case the offsets and the selector keep their values and `rd_valid_o` stays 0. While `load_sel_i`=1, both `fifo_wr_o` and `fifo_rd_o` are 0.
- R7: OFS_W is 12 for a DEPTH below 4096 and 16 otherwise. Bits of `data_i` above OFS_W are ignored on a write, and `data_o` bits above OFS_W read back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Shared write/read clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| load_sel_i | input | 1 | Routes accesses to the offset registers |
| wr_en_i | input | 1 | Write enable |
| rd_en_i | input | 1 | Read enable |
| data_i | input | DATA_W | FIFO data input, carries offset on load |
| data_o | output | DATA_W | Read-back offset, zero-extended |
| rd_valid_o | output | 1 | One-cycle pulse after a load read |
| fifo_wr_o | output | 1 | Write enable passed to the FIFO |
| fifo_rd_o | output | 1 | Read enable passed to the FIFO |
| ae_ofs_o | output | OFS_W | Almost-empty offset to flag logic |
| af_ofs_o | output | OFS_W | Almost-full offset to flag logic |

## Verification
A load write and a load read can land on the same edge. Both then target the one offset the selector points at, and the selector must still move only once. The bench provokes this by raising both enables together with load-select while the selector points at the almost-full offset. The returned word must be the old value. The new value must then appear on `af_ofs_o`, and the next two reads must return the almost-empty offset and then the new almost-full offset.

// File: rtl/flag_ofs_pkg.sv
package flag_ofs_pkg;
  typedef enum logic {
    SEL_AE = 1'b0,
    SEL_AF = 1'b1
  } ofs_sel_e;
endpackage

// File: rtl/ofs_selector.sv
module ofs_selector
  import flag_ofs_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     step_i,
  output ofs_sel_e sel_o
);
  ofs_sel_e sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sel_q <= SEL_AE;
    else if (step_i) sel_q <= (sel_q == SEL_AE) ? SEL_AF : SEL_AE;
  end

  assign sel_o = sel_q;

  // R3
  sel_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |=> sel_q != $past(sel_q));
  // R3
  sel_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(sel_q));
endmodule

// File: rtl/ofs_regs.sv
module ofs_regs
  import flag_ofs_pkg::*;
#(
  parameter int          OFS_W   = 12,
  parameter logic [15:0] DEF_OFS = 16'd7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  ofs_sel_e         sel_i,
  input  logic [OFS_W-1:0] wdata_i,
  output logic [OFS_W-1:0] ae_o,
  output logic [OFS_W-1:0] af_o
);
  localparam int NREG = 2;
  logic [OFS_W-1:0] ofs_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          ofs_q[g] <= DEF_OFS[OFS_W-1:0];
      else if (wr_i && (int'(sel_i) == g)) ofs_q[g] <= wdata_i;
    end
  end

  assign ae_o = ofs_q[SEL_AE];
  assign af_o = ofs_q[SEL_AF];

  // R2
  ae_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && sel_i == SEL_AE) |=> ae_o == $past(wdata_i) && $stable(af_o));
  // R2
  af_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && sel_i == SEL_AF) |=> af_o == $past(wdata_i) && $stable(ae_o));
  // R6
  ofs_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(ae_o) && $stable(af_o));
endmodule

// File: rtl/ofs_rdport.sv
module ofs_rdport
  import flag_ofs_pkg::*;
#(
  parameter int DATA_W = 18,
  parameter int OFS_W  = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_i,
  input  ofs_sel_e          sel_i,
  input  logic [OFS_W-1:0]  ae_i,
  input  logic [OFS_W-1:0]  af_i,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o
);
  logic [OFS_W-1:0] pick;
  assign pick = (sel_i == SEL_AF) ? af_i : ae_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= rd_i;
      if (rd_i) data_o <= DATA_W'(pick);
    end
  end

  // R7
  rd_upper_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (data_o >> OFS_W) == '0);
  // R4
  rd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(data_o) && !valid_o);
endmodule

// File: rtl/flag_ofs_loader.sv
module flag_ofs_loader
  import flag_ofs_pkg::*;
#(
  parameter int          DEPTH   = 512,
  parameter int          DATA_W  = 18,
  parameter int          OFS_W   = (DEPTH >= 4096) ? 16 : 12,
  parameter logic [15:0] DEF_OFS = 16'd7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_sel_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              rd_valid_o,
  output logic              fifo_wr_o,
  output logic              fifo_rd_o,
  output logic [OFS_W-1:0]  ae_ofs_o,
  output logic [OFS_W-1:0]  af_ofs_o
);
  logic     ld_wr, ld_rd;
  ofs_sel_e sel;

  assign ld_wr     = load_sel_i & wr_en_i;
  assign ld_rd     = load_sel_i & rd_en_i;
  assign fifo_wr_o = ~load_sel_i & wr_en_i;
  assign fifo_rd_o = ~load_sel_i & rd_en_i;

  ofs_selector u_sel (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (ld_wr | ld_rd),
    .sel_o  (sel)
  );

  ofs_regs #(.OFS_W(OFS_W), .DEF_OFS(DEF_OFS)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (ld_wr),
    .sel_i   (sel),
    .wdata_i (data_i[OFS_W-1:0]),
    .ae_o    (ae_ofs_o),
    .af_o    (af_ofs_o)
  );

  ofs_rdport #(.DATA_W(DATA_W), .OFS_W(OFS_W)) u_rd (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rd_i    (ld_rd),
    .sel_i   (sel),
    .ae_i    (ae_ofs_o),
    .af_i    (af_ofs_o),
    .data_o  (data_o),
    .valid_o (rd_valid_o)
  );

  // R6
  fifo_isolate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_sel_i && (fifo_wr_o || fifo_rd_o)) == 1'b0);
endmodule

// File: tb/tb_flag_ofs_loader.sv
module tb_flag_ofs_loader;
  localparam int DATA_W = 18;
  localparam int OFS_W  = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ls = 1'b0, we = 1'b0, re = 1'b0;
  logic [DATA_W-1:0] din = '0;
  logic [DATA_W-1:0] dout;
  logic rv, fwr, frd;
  logic [OFS_W-1:0] ae, af;

  int total = 0, bad = 0;
  logic [DATA_W-1:0] exp_q[$];
  logic [OFS_W-1:0] m_ae = 12'd7, m_af = 12'd7;
  logic m_sel = 1'b0;

  always #10 clk = ~clk;

  flag_ofs_loader #(.DEPTH(512), .DATA_W(DATA_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .load_sel_i(ls), .wr_en_i(we), .rd_en_i(re),
    .data_i(din), .data_o(dout), .rd_valid_o(rv), .fifo_wr_o(fwr),
    .fifo_rd_o(frd), .ae_ofs_o(ae), .af_ofs_o(af)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops one expected word per read pulse
  always @(negedge clk) begin
    if (rst_n && rv) begin
      if (exp_q.size() == 0) check("R4 unexpected rd_valid", 32'(dout), 32'hdead);
      else check("R4/R5 readback", 32'(dout), 32'(exp_q.pop_front()));
    end
  end

  task automatic op(logic l, logic w, logic r, logic [DATA_W-1:0] d);
    @(negedge clk);
    ls = l; we = w; re = r; din = d;
    #1;
    check("R6 fifo_wr", 32'(fwr), 32'(!l && w));
    check("R6 fifo_rd", 32'(frd), 32'(!l && r));
    if (l && r) exp_q.push_back(DATA_W'(m_sel ? m_af : m_ae));
    if (l && w) begin
      if (m_sel) m_af = d[OFS_W-1:0];
      else       m_ae = d[OFS_W-1:0];
    end
    if (l && (w || r)) m_sel = ~m_sel;
    @(posedge clk);
    #1;
    ls = 0; we = 0; re = 0;
    check("R2 ae_ofs", 32'(ae), 32'(m_ae));
    check("R2 af_ofs", 32'(af), 32'(m_af));
  endtask

  initial begin
    #(200000 * 20);
    check("watchdog", 32'd1, 32'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check("R1 ae reset", 32'(ae), 32'd7);
    check("R1 af reset", 32'(af), 32'd7);
    check("R1 data_o reset", 32'(dout), 32'd0);
    check("R1 rd_valid reset", 32'(rv), 32'd0);
    // R2 R3: ae then af
    op(1, 1, 0, 18'h00123);
    op(1, 1, 0, 18'h00abc);
    // R3 wrap, R7 upper bits dropped
    op(1, 1, 0, 18'h3f456);
    check("R7 ae masked", 32'(ae), 32'h456);
    // R4 reads follow selector: af, then ae
    op(1, 0, 1, '0);
    op(1, 0, 1, '0);
    // R6 pass-through leaves state alone
    op(0, 1, 1, 18'h00fff);
    @(negedge clk);
    check("R6 no rd_valid", 32'(rv), 32'd0);
    check("R4 data_o held", 32'(dout), 32'h456);
    // R5 simultaneous write and read on af
    op(1, 1, 1, 18'h00777);
    op(1, 0, 1, '0);
    op(1, 0, 1, '0);
    // R7 read back of a full-width value
    op(1, 1, 0, 18'h3ffff);
    op(1, 0, 1, '0);
    op(1, 0, 1, '0);
    repeat (3) @(negedge clk);
    check("R4 all reads seen", 32'(exp_q.size()), 32'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule